// File: doc/BRIEF.md
# Pipeline Fetch Stage Controller

This block decides, once per clock, what the fetch stage of an out-of-order pipeline does next. It watches redirect requests from the commit and decode stages, a flag saying that the reorder buffer is still being flushed, stall flags from four downstream stages, and the outcome of the instruction cache access made in a fetch cycle: a hit, a miss, a completed fill or a fault. From these it keeps a five-state status register and the fetch PC and next-PC registers, and it raises a fetch-enable towards the logic that forms instruction groups.

The inputs are resolved in a fixed priority order every cycle. A commit redirect wins over everything. A reorder-buffer flush hold comes next, then a decode redirect, then any stall, then leaving the blocked state, then leaving the squashing state. Every recovery path spends one cycle with fetch disabled before fetching resumes. A commit redirect that carries a branch mispredict also sends an update strobe to the branch predictor. A redirect that lands while a cache miss is outstanding sends a cancel to the cache. A fault raised by the cache in a fetch cycle is passed on to the reorder buffer, and the stage blocks.

Top module: `fetch_stage_ctrl`

## Requirements
- R1: After a synchronous active-low reset the status is Running (code 0), the PC equals the parameter RESET_PC, next-PC equals RESET_PC + INST_BYTES, and with all inputs quiet fetch_en_o is high in the first cycle after reset is released. Status codes: Running 0, Blocked 1, Squashing 2, MissWait 3, MissDone 4.
- R2: When cmt_squash_i is high, whatever the other inputs, fetch_en_o is low in that cycle, and after the edge the PC equals cmt_redirect_pc_i, next-PC equals it plus INST_BYTES, and the status is Squashing.
- R3: In a cycle with cmt_squash_i and cmt_mispredict_i both high, bp_upd_o is high, with bp_upd_pc_o equal to cmt_mispredict_pc_i, bp_upd_taken_o equal to cmt_taken_i and bp_upd_target_o equal to cmt_redirect_pc_i. bp_upd_o is low in every other cycle.
- R4: Without a commit redirect, rob_squashing_i high keeps fetch_en_o low and moves the status to Squashing, with PC and next-PC unchanged.
- R5: A decode redirect (dec_squash_i) with no higher-priority condition loads the PC from dec_redirect_pc_i and next-PC with that value plus INST_BYTES, enters Squashing and disables fetch. While the status is already Squashing a decode redirect has no effect: PC and next-PC do not change.
- R6: If any bit of stall_i is high and no redirect or flush hold applies, the status becomes Blocked and fetch_en_o is low, whatever the current status.
- R7: In Blocked with no stall bit high and no redirect, the status returns to Running and fetch_en_o stays low in that cycle.
- R8: In Squashing with no redirect, flush hold or stall, the status returns to Running and fetch_en_o stays low in that cycle.
- R9: miss_cancel_o is high in a cycle where a commit redirect, or a decode redirect that takes effect, arrives while the status is MissWait. It is low otherwise.
- R10: In a fetch cycle, fault_i raises fault_o with fault_code_o equal to fault_code_i, and the status becomes Blocked. fault_o is never high outside a fetch cycle.
- R11: In a fetch cycle, cache_miss_i (without fault_i) moves the status to MissWait. MissWait does not fetch. fill_done_i in MissWait moves the status to MissDone. MissDone fetches and returns to Running.
- R12: In a fetch cycle with grp_adv_i high and neither fault_i nor cache_miss_i high, the PC is loaded from grp_next_pc_i and next-PC with that value plus INST_BYTES. Otherwise a fetch cycle leaves both registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmt_squash_i | input | 1 | Redirect request from commit |
| cmt_redirect_pc_i | input | ADDR_W | Redirect target from commit |
| cmt_mispredict_i | input | 1 | The commit redirect is a branch mispredict |
| cmt_mispredict_pc_i | input | ADDR_W | PC of the mispredicted branch |
| cmt_taken_i | input | 1 | Actual direction of that branch |
| rob_squashing_i | input | 1 | Reorder buffer still flushing |
| dec_squash_i | input | 1 | Redirect request from decode |
| dec_redirect_pc_i | input | ADDR_W | Redirect target from decode |
| stall_i | input | N_STALL | Stall flags from downstream stages |
| cache_miss_i | input | 1 | Cache missed on this fetch |
| fill_done_i | input | 1 | Outstanding miss has been filled |
| fault_i | input | 1 | Fetch access faulted |
| fault_code_i | input | FAULT_W | Kind of fault |
| grp_adv_i | input | 1 | Group former consumed the fetch and supplies a PC |
| grp_next_pc_i | input | ADDR_W | PC after the fetched group |
| fetch_en_o | output | 1 | Fetch this cycle |
| pc_o | output | ADDR_W | Fetch PC register |
| next_pc_o | output | ADDR_W | Next-PC register |
| status_o | output | 3 | Status code |
| bp_upd_o | output | 1 | Predictor update strobe |
| bp_upd_pc_o | output | ADDR_W | Branch PC for the update |
| bp_upd_taken_o | output | 1 | Direction for the update |
| bp_upd_target_o | output | ADDR_W | Target for the update |
| miss_cancel_o | output | 1 | Cancel the outstanding cache miss |
| fault_o | output | 1 | Fault report to the reorder buffer |
| fault_code_o | output | FAULT_W | Fault kind for the report |

## Verification
The assertions cover the local cause-and-effect rules on every cycle: a commit redirect is never paired with a fetch and always lands in the PC one edge later, a flush hold or a stall forces its status, no fetch happens in Blocked or MissWait, and the predictor strobe, cancel and fault report only appear under their own conditions. Only the bench's scenarios show the full priority ordering when several requests collide. They also show that a decode redirect is ignored while squashing, that the PC moves with the group former, and that the sequence from a miss through its fill back to Running completes.

// File: rtl/fetch_ctrl_pkg.sv
// Shared types for the fetch stage controller.
// Assumes: status codes are visible at the top port and must stay fixed.
package fetch_ctrl_pkg;

    // Stage status; values are observable on status_o.
    typedef enum logic [2:0] {
        ST_RUN       = 3'd0,
        ST_BLOCK     = 3'd1,
        ST_SQUASH    = 3'd2,
        ST_MISS_WAIT = 3'd3,
        ST_MISS_DONE = 3'd4
    } fstat_t;

    // Action chosen by the priority chain for the current cycle.
    typedef enum logic [2:0] {
        ACT_CMT_SQ   = 3'd0,
        ACT_ROB_HOLD = 3'd1,
        ACT_DEC_SQ   = 3'd2,
        ACT_STALL    = 3'd3,
        ACT_UNBLOCK  = 3'd4,
        ACT_SQ_EXIT  = 3'd5,
        ACT_FETCH    = 3'd6,
        ACT_WAIT     = 3'd7
    } fact_t;

endpackage

// File: rtl/fetch_prio.sv
// Priority chain: picks one action per cycle from the request inputs
// and the current status. Purely combinational.
// Assumes: the stall vector is at least one bit wide.
module fetch_prio
    import fetch_ctrl_pkg::*;
#(
    parameter int N_STALL = 4
) (
    input  fstat_t             status,
    input  logic               cmt_sq,
    input  logic               rob_sq,
    input  logic               dec_sq,
    input  logic [N_STALL-1:0] stall,
    output fact_t              act
);

    logic any_stall;

    // Collapse the downstream stall flags into one.
    always_comb begin
        any_stall = 1'b0;
        for (int k = 0; k < N_STALL; k++) begin
            any_stall = any_stall | stall[k];
        end
    end

    // Resolve the requests in fixed priority order.
    always_comb begin
        if (cmt_sq) begin
            act = ACT_CMT_SQ;
        end else if (rob_sq) begin
            act = ACT_ROB_HOLD;
        end else if (dec_sq && (status != ST_SQUASH)) begin
            act = ACT_DEC_SQ;
        end else if (any_stall) begin
            act = ACT_STALL;
        end else if (status == ST_BLOCK) begin
            act = ACT_UNBLOCK;
        end else if (status == ST_SQUASH) begin
            act = ACT_SQ_EXIT;
        end else if (status == ST_MISS_WAIT) begin
            act = ACT_WAIT;
        end else begin
            act = ACT_FETCH;
        end
    end

endmodule

// File: rtl/fetch_status_reg.sv
// Status register of the fetch stage. The next status follows from the
// chosen action and, in fetch or wait cycles, from the cache outcome.
// Assumes: fault takes precedence over miss in the same fetch cycle.
module fetch_status_reg
    import fetch_ctrl_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  fact_t  act,
    input  logic   fault,
    input  logic   miss,
    input  logic   fill_done,
    output fstat_t status
);

    fstat_t status_nxt;

    // Next-status selection.
    always_comb begin
        unique case (act)
            ACT_CMT_SQ, ACT_ROB_HOLD, ACT_DEC_SQ: status_nxt = ST_SQUASH;
            ACT_STALL:                            status_nxt = ST_BLOCK;
            ACT_UNBLOCK, ACT_SQ_EXIT:             status_nxt = ST_RUN;
            ACT_WAIT:    status_nxt = fill_done ? ST_MISS_DONE : ST_MISS_WAIT;
            ACT_FETCH: begin
                if (fault) begin
                    status_nxt = ST_BLOCK;
                end else if (miss) begin
                    status_nxt = ST_MISS_WAIT;
                end else begin
                    status_nxt = ST_RUN;
                end
            end
            default:                              status_nxt = ST_RUN;
        endcase
    end

    // Status register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= ST_RUN;
        end else begin
            status <= status_nxt;
        end
    end

endmodule

// File: rtl/fetch_pc_reg.sv
// PC and next-PC registers. A load writes the PC and sets next-PC to
// the loaded value plus one instruction.
// Assumes: the caller resolves which source is loaded.
module fetch_pc_reg #(
    parameter int              ADDR_W     = 32,
    parameter int              INST_BYTES = 4,
    parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_pc,
    output logic [ADDR_W-1:0] pc,
    output logic [ADDR_W-1:0] next_pc
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INST_BYTES);

    // PC pair update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc      <= RESET_PC;
            next_pc <= RESET_PC + STEP;
        end else if (load) begin
            pc      <= load_pc;
            next_pc <= load_pc + STEP;
        end
    end

endmodule

// File: rtl/fetch_stage_ctrl.sv
// Fetch stage controller top. Resolves redirects, flush holds and stalls
// in fixed priority, keeps status and PC registers, and drives the fetch
// enable, predictor update, miss cancel and fault report.
// Assumes: cache_miss_i, fault_i and grp_adv_i describe the access made
// in the current cycle and are only meaningful while fetch_en_o is high.
module fetch_stage_ctrl
    import fetch_ctrl_pkg::*;
#(
    parameter int                ADDR_W     = 32,
    parameter int                INST_BYTES = 4,
    parameter int                N_STALL    = 4,
    parameter int                FAULT_W    = 4,
    parameter logic [ADDR_W-1:0] RESET_PC   = 32'h0000_1000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmt_squash_i,
    input  logic [ADDR_W-1:0]  cmt_redirect_pc_i,
    input  logic               cmt_mispredict_i,
    input  logic [ADDR_W-1:0]  cmt_mispredict_pc_i,
    input  logic               cmt_taken_i,
    input  logic               rob_squashing_i,
    input  logic               dec_squash_i,
    input  logic [ADDR_W-1:0]  dec_redirect_pc_i,
    input  logic [N_STALL-1:0] stall_i,
    input  logic               cache_miss_i,
    input  logic               fill_done_i,
    input  logic               fault_i,
    input  logic [FAULT_W-1:0] fault_code_i,
    input  logic               grp_adv_i,
    input  logic [ADDR_W-1:0]  grp_next_pc_i,
    output logic               fetch_en_o,
    output logic [ADDR_W-1:0]  pc_o,
    output logic [ADDR_W-1:0]  next_pc_o,
    output logic [2:0]         status_o,
    output logic               bp_upd_o,
    output logic [ADDR_W-1:0]  bp_upd_pc_o,
    output logic               bp_upd_taken_o,
    output logic [ADDR_W-1:0]  bp_upd_target_o,
    output logic               miss_cancel_o,
    output logic               fault_o,
    output logic [FAULT_W-1:0] fault_code_o
);

    fstat_t            status;
    fact_t             act;
    logic              fetching;
    logic              pc_load;
    logic [ADDR_W-1:0] pc_src;

    fetch_prio #(
        .N_STALL (N_STALL)
    ) i_prio (
        .status (status),
        .cmt_sq (cmt_squash_i),
        .rob_sq (rob_squashing_i),
        .dec_sq (dec_squash_i),
        .stall  (stall_i),
        .act    (act)
    );

    fetch_status_reg i_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .act       (act),
        .fault     (fault_i),
        .miss      (cache_miss_i),
        .fill_done (fill_done_i),
        .status    (status)
    );

    // Pick the PC source for this cycle, if any.
    always_comb begin
        pc_load = 1'b0;
        pc_src  = grp_next_pc_i;
        unique case (act)
            ACT_CMT_SQ: begin
                pc_load = 1'b1;
                pc_src  = cmt_redirect_pc_i;
            end
            ACT_DEC_SQ: begin
                pc_load = 1'b1;
                pc_src  = dec_redirect_pc_i;
            end
            ACT_FETCH: begin
                pc_load = grp_adv_i && !fault_i && !cache_miss_i;
            end
            default: ;
        endcase
    end

    fetch_pc_reg #(
        .ADDR_W     (ADDR_W),
        .INST_BYTES (INST_BYTES),
        .RESET_PC   (RESET_PC)
    ) i_pc (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (pc_load),
        .load_pc (pc_src),
        .pc      (pc_o),
        .next_pc (next_pc_o)
    );

    // Strobes towards the group former, predictor, cache and reorder buffer.
    always_comb begin
        fetching        = rst_n && (act == ACT_FETCH);
        fetch_en_o      = fetching;
        bp_upd_o        = rst_n && cmt_squash_i && cmt_mispredict_i;
        bp_upd_pc_o     = cmt_mispredict_pc_i;
        bp_upd_taken_o  = cmt_taken_i;
        bp_upd_target_o = cmt_redirect_pc_i;
        miss_cancel_o   = rst_n && (status == ST_MISS_WAIT) &&
                          ((act == ACT_CMT_SQ) || (act == ACT_DEC_SQ));
        fault_o         = fetching && fault_i;
        fault_code_o    = fault_code_i;
        status_o        = status;
    end

endmodule

// File: rtl/fetch_stage_ctrl_chk.sv
// Property checker for the fetch stage controller, bound to the top.
// Assumes: it sees only the top's ports.
module fetch_stage_ctrl_chk #(
    parameter int ADDR_W  = 32,
    parameter int N_STALL = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cmt_squash_i,
    input logic [ADDR_W-1:0]  cmt_redirect_pc_i,
    input logic               cmt_mispredict_i,
    input logic               rob_squashing_i,
    input logic               dec_squash_i,
    input logic [N_STALL-1:0] stall_i,
    input logic               fetch_en_o,
    input logic [ADDR_W-1:0]  pc_o,
    input logic [2:0]         status_o,
    input logic               bp_upd_o,
    input logic               miss_cancel_o,
    input logic               fault_o
);

    assert_cmt_no_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmt_squash_i |-> !fetch_en_o);

    assert_cmt_redirect_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmt_squash_i |=> (pc_o == $past(cmt_redirect_pc_i)) && (status_o == 3'd2));

    assert_bp_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bp_upd_o |-> (cmt_squash_i && cmt_mispredict_i));

    assert_rob_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmt_squash_i && rob_squashing_i) |=> (status_o == 3'd2));

    assert_stall_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmt_squash_i && !rob_squashing_i && !(dec_squash_i && status_o != 3'd2)
         && (stall_i != '0)) |=> (status_o == 3'd1));

    assert_blocked_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o == 3'd1) |-> !fetch_en_o);

    assert_cancel_only_in_miss_R9: assert property (@(posedge clk) disable iff (!rst_n)
        miss_cancel_o |-> (status_o == 3'd3));

    assert_fault_in_fetch_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> fetch_en_o);

    assert_miss_wait_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o == 3'd3) |-> !fetch_en_o);

    assert_status_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        status_o <= 3'd4);

endmodule

bind fetch_stage_ctrl fetch_stage_ctrl_chk #(
    .ADDR_W  (ADDR_W),
    .N_STALL (N_STALL)
) i_chk (
    .clk               (clk),
    .rst_n             (rst_n),
    .cmt_squash_i      (cmt_squash_i),
    .cmt_redirect_pc_i (cmt_redirect_pc_i),
    .cmt_mispredict_i  (cmt_mispredict_i),
    .rob_squashing_i   (rob_squashing_i),
    .dec_squash_i      (dec_squash_i),
    .stall_i           (stall_i),
    .fetch_en_o        (fetch_en_o),
    .pc_o              (pc_o),
    .status_o          (status_o),
    .bp_upd_o          (bp_upd_o),
    .miss_cancel_o     (miss_cancel_o),
    .fault_o           (fault_o)
);

// File: tb/test_fetch_stage_ctrl.sv
// Bench: behavioural reference model of the status and PC rules,
// compared with the design in every clock cycle.
module test_fetch_stage_ctrl;

    localparam int          AW  = 32;
    localparam int          ISZ = 4;
    localparam int          NS  = 4;
    localparam int          FW  = 4;
    localparam logic [31:0] RV  = 32'h0000_1000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmt_sq = 0, cmt_mis = 0, cmt_tk = 0, rob_sq = 0, dec_sq = 0;
    logic [AW-1:0] cmt_pc = '0, cmt_mpc = '0, dec_pc = '0, grp_pc = '0;
    logic [NS-1:0] stall = '0;
    logic          miss = 0, fill = 0, flt = 0, adv = 0;
    logic [FW-1:0] fcode = '0;

    logic          fetch_en, bp_upd, bp_tk, cancel, fault_o;
    logic [AW-1:0] pc, npc, bp_pc, bp_tgt;
    logic [2:0]    status;
    logic [FW-1:0] fault_code;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // model state
    int            m_st = 0;
    logic [AW-1:0] m_pc = RV, m_npc = RV + ISZ;
    string         prev_tag = "R1";

    always #5 clk = ~clk;

    fetch_stage_ctrl #(.ADDR_W(AW), .INST_BYTES(ISZ), .N_STALL(NS),
                       .FAULT_W(FW), .RESET_PC(RV)) i_fetch_stage_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cmt_squash_i(cmt_sq), .cmt_redirect_pc_i(cmt_pc),
        .cmt_mispredict_i(cmt_mis), .cmt_mispredict_pc_i(cmt_mpc),
        .cmt_taken_i(cmt_tk), .rob_squashing_i(rob_sq),
        .dec_squash_i(dec_sq), .dec_redirect_pc_i(dec_pc),
        .stall_i(stall), .cache_miss_i(miss), .fill_done_i(fill),
        .fault_i(flt), .fault_code_i(fcode),
        .grp_adv_i(adv), .grp_next_pc_i(grp_pc),
        .fetch_en_o(fetch_en), .pc_o(pc), .next_pc_o(npc), .status_o(status),
        .bp_upd_o(bp_upd), .bp_upd_pc_o(bp_pc), .bp_upd_taken_o(bp_tk),
        .bp_upd_target_o(bp_tgt), .miss_cancel_o(cancel),
        .fault_o(fault_o), .fault_code_o(fault_code));

    task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic quiet();
        cmt_sq = 0; cmt_mis = 0; cmt_tk = 0; rob_sq = 0; dec_sq = 0;
        stall = '0; miss = 0; fill = 0; flt = 0; adv = 0;
    endtask

    // One cycle: compare outputs against the model, then advance both.
    task automatic tick();
        int a;
        string tag;
        bit e_fe, e_bp, e_can, e_flt;
        #1;
        if (rst_n) begin
            if (cmt_sq)                   begin a = 0; tag = "R2"; end
            else if (rob_sq)              begin a = 1; tag = "R4"; end
            else if (dec_sq && m_st != 2) begin a = 2; tag = "R5"; end
            else if (stall != '0)         begin a = 3; tag = "R6"; end
            else if (m_st == 1)           begin a = 4; tag = "R7"; end
            else if (m_st == 2)           begin a = 5; tag = dec_sq ? "R5" : "R8"; end
            else if (m_st == 3)           begin a = 7; tag = "R11"; end
            else begin
                a = 6;
                tag = flt ? "R10" : (miss || m_st == 4) ? "R11" : "R12";
            end
            e_fe  = (a == 6);
            e_bp  = cmt_sq && cmt_mis;
            e_can = (a == 0 || a == 2) && m_st == 3;
            e_flt = e_fe && flt;
            chk(prev_tag, "status", 64'(status), 64'(m_st));
            chk(prev_tag, "pc", 64'(pc), 64'(m_pc));
            chk(prev_tag, "next_pc", 64'(npc), 64'(m_npc));
            chk(tag, "fetch_en", 64'(fetch_en), 64'(e_fe));
            chk("R3", "bp_upd", 64'(bp_upd), 64'(e_bp));
            if (e_bp) begin
                chk("R3", "bp_pc", 64'(bp_pc), 64'(cmt_mpc));
                chk("R3", "bp_taken", 64'(bp_tk), 64'(cmt_tk));
                chk("R3", "bp_target", 64'(bp_tgt), 64'(cmt_pc));
            end
            chk("R9", "miss_cancel", 64'(cancel), 64'(e_can));
            chk("R10", "fault", 64'(fault_o), 64'(e_flt));
            if (e_flt) chk("R10", "fault_code", 64'(fault_code), 64'(fcode));
            // model next state
            case (a)
                0: begin m_st = 2; m_pc = cmt_pc; m_npc = cmt_pc + ISZ; end
                1: m_st = 2;
                2: begin m_st = 2; m_pc = dec_pc; m_npc = dec_pc + ISZ; end
                3: m_st = 1;
                4, 5: m_st = 0;
                7: m_st = fill ? 4 : 3;
                default: begin
                    if (flt) m_st = 1;
                    else if (miss) m_st = 3;
                    else begin
                        m_st = 0;
                        if (adv) begin m_pc = grp_pc; m_npc = grp_pc + ISZ; end
                    end
                end
            endcase
            prev_tag = tag;
        end
        @(posedge clk);
        if (!rst_n) begin
            m_st = 0; m_pc = RV; m_npc = RV + ISZ; prev_tag = "R1";
        end
        @(negedge clk);
    endtask

    initial begin
        @(negedge clk);
        quiet();
        tick(); tick();
        rst_n = 1;
        // R1: reset state and first fetch
        #1;
        chk("R1", "reset status", 64'(status), 64'd0);
        chk("R1", "reset pc", 64'(pc), 64'(RV));
        chk("R1", "reset next_pc", 64'(npc), 64'(RV + ISZ));
        chk("R1", "first fetch_en", 64'(fetch_en), 64'd1);
        tick();
        // R12: plain fetches advancing the PC
        adv = 1; grp_pc = 32'h1010; tick();
        grp_pc = 32'h1020; tick();
        adv = 0; tick();
        // R2/R3: commit mispredict redirect beats stall, rob hold, decode
        cmt_sq = 1; cmt_mis = 1; cmt_tk = 1; cmt_pc = 32'h2000; cmt_mpc = 32'h101c;
        stall = 4'b0100; rob_sq = 1; dec_sq = 1; dec_pc = 32'h3000; tick();
        quiet(); tick();           // R8 exit
        tick();                    // fetch
        // R2 without mispredict: no predictor strobe
        cmt_sq = 1; cmt_pc = 32'h2100; tick();
        quiet();
        // R4: flush hold then release
        rob_sq = 1; tick(); tick(); rob_sq = 0; tick(); tick();
        // R5: decode redirect, then ignored while squashing
        dec_sq = 1; dec_pc = 32'h3000; tick();
        dec_pc = 32'h3300; tick();
        quiet(); tick();
        // R6/R7: stall each bit, hold, release
        for (int b = 0; b < NS; b++) begin
            stall = NS'(1) << b; tick(); tick();
            stall = '0; tick(); tick();
        end
        // R11: miss, wait, fill, resume (adv during miss must not load PC)
        miss = 1; adv = 1; grp_pc = 32'h4444; tick();
        quiet(); tick(); tick();
        fill = 1; tick();
        fill = 0; adv = 1; grp_pc = 32'h3010; tick();
        quiet(); tick();
        // R9: commit redirect during miss cancels it
        miss = 1; tick(); quiet(); tick();
        cmt_sq = 1; cmt_pc = 32'h5000; tick(); quiet(); tick(); tick();
        // R9: decode redirect during miss cancels it
        miss = 1; tick(); quiet();
        dec_sq = 1; dec_pc = 32'h6000; tick(); quiet(); tick(); tick();
        // R6: stall during miss wait blocks, no cancel
        miss = 1; tick(); quiet();
        stall = 4'b1000; tick(); stall = '0; tick(); tick();
        // R10: fault in fetch, with miss also high
        flt = 1; miss = 1; fcode = 4'ha; adv = 1; grp_pc = 32'h7777; tick();
        quiet(); tick(); tick();
        // R10: fault ignored outside a fetch cycle
        stall = 4'b0001; flt = 1; tick(); quiet(); tick(); tick();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog R1-run actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule